// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block turns parallel bytes into a framed serial bit stream and recovers bytes from an incoming serial line. A seven-bit mode word, captured on a write strobe, fixes the framing. It selects one or two stop bits and an optional parity bit with even or odd sense. It can switch on a multiprocessor format, in which a flag bit takes the place of parity. It also holds a two-bit prescaler choice that, together with an 8-bit reload input, sets the bit rate. The line is sampled sixteen times per bit.

A byte is offered on a valid/ready handshake and is taken only while the transmitter is idle. Received bytes appear with a one-cycle valid pulse, the multiprocessor flag and framing and parity error flags. A synchronous mode setting reduces the transmit frame to the bare data bits and silences the receiver. In that mode the stop-length, parity and multiprocessor settings have no effect.

Top module: `ser_framer`

## Requirements
- R1: After reset the transmit line and `tx_ready_o` are high, `rx_valid_o` is low, and the mode word is all zero, which means asynchronous mode, one stop bit, no parity, multiprocessor format off and clock select 00.
- R2: An asynchronous frame is a low start bit, then 8 data bits LSB first, then the optional extra bit, then the stop bits, which are high. Each bit lasts 16 oversampling ticks. `tx_ready_o` falls on the cycle after a byte is accepted and stays low for the whole frame. Received data matches the transmitted byte.
- R3: Mode bit 1 (`two_stop`) set to 0 appends one stop bit and set to 1 appends two. The transmitter stays busy for 16 ticks times the frame's bit count.
- R4: With mode bit 3 (`par_en`) set and mode bit 2 (`mp_fmt`) clear, a parity bit follows the data. Mode bit 4 (`par_odd`) at 0 selects even parity and at 1 selects odd parity. The receiver raises `rx_parity_err_o` when the received parity bit mismatches.
- R5: With mode bit 2 (`mp_fmt`) set, the extra bit carries `tx_mpb_i` and is reported on `rx_mpb_o`. The parity settings are ignored, and no parity error is ever flagged.
- R6: The receiver checks only the first stop bit. If that bit is low, `rx_frame_err_o` is raised with the byte. A low line in the slot of a second stop bit is taken as the start bit of the next character.
- R7: Mode bits 6:5 (`clk_sel`) select a prescale of 1, 4, 16 or 64 for the values 00, 01, 10 and 11. One oversampling tick lasts prescale × (`brr_i` + 1) clock cycles.
- R8: With mode bit 0 (`sync_mode`) set, the transmitter sends only the 8 data bits, LSB first, at 16 ticks each. No start, stop, parity or flag bit is sent, whatever the other mode bits say. The receiver produces no output in this mode.
- R9: A low pulse on the receive line that is gone by the mid-bit check (sample 8 of 16) does not start a character.
- R10: `rx_valid_o` is a single-cycle pulse for each received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| mode_wr_i | input | 1 | Loads `mode_i` into the mode register |
| mode_i | input | 7 | Mode word: [6:5] clk_sel, [4] par_odd, [3] par_en, [2] mp_fmt, [1] two_stop, [0] sync_mode |
| brr_i | input | 8 | Bit-rate counter reload value |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_data_i | input | 8 | Transmit byte |
| tx_mpb_i | input | 1 | Multiprocessor flag to send with the byte (1 = ID character) |
| tx_ready_o | output | 1 | Transmitter idle and able to take a byte |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |
| rx_valid_o | output | 1 | One-cycle pulse: received character available |
| rx_data_o | output | 8 | Received byte |
| rx_mpb_o | output | 1 | Received multiprocessor flag |
| rx_frame_err_o | output | 1 | First stop bit was low |
| rx_parity_err_o | output | 1 | Parity bit mismatched |

## Verification
The assertions assume that the mode word and `brr_i` change only while both the transmitter and the receiver are idle. Under that assumption, the settings that the prescaler, the framer and the error logic see stay fixed for the length of a character. The stimulus writes the mode and changes the reload value only after the previous frame has drained, with the receive line held high. It offers a byte only when `tx_ready_o` is high. Hand-built receive frames are clocked at exactly 16 ticks per bit, so the mid-bit samples fall well inside each bit.

// File: rtl/ser_framer_pkg.sv
package ser_framer_pkg;

    // Mode word layout, MSB first: [6:5] clk_sel .. [0] sync_mode
    typedef struct packed {
        logic [1:0] clk_sel;
        logic       par_odd;
        logic       par_en;
        logic       mp_fmt;
        logic       two_stop;
        logic       sync_mode;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_EXTRA,
        PH_STOP
    } phase_e;

endpackage

// File: rtl/ser_rate_gen.sv
module ser_rate_gen #(
    parameter int BRR_W = 8,
    parameter int PRE_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       clk_sel_i,
    input  logic [BRR_W-1:0] brr_i,
    output logic             os_tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre_cnt;
        logic [BRR_W-1:0] brr_cnt;
    } rate_t;

    rate_t q, d;
    logic [PRE_W-1:0] pre_last;
    logic             pre_tick;

    always_comb begin
        case (clk_sel_i)
            2'b00:   pre_last = PRE_W'(0);
            2'b01:   pre_last = PRE_W'(3);
            2'b10:   pre_last = PRE_W'(15);
            default: pre_last = PRE_W'(63);
        endcase
        d         = q;
        pre_tick  = (q.pre_cnt >= pre_last);
        os_tick_o = pre_tick && (q.brr_cnt >= brr_i);
        d.pre_cnt = pre_tick ? '0 : q.pre_cnt + 1'b1;
        if (pre_tick) begin
            d.brr_cnt = os_tick_o ? '0 : q.brr_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // R7: ticks are spaced apart whenever the divide ratio exceeds one
    assert_tick_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (os_tick_o && (clk_sel_i != 2'b00 || brr_i != '0))
        |=> (!os_tick_o || !$stable(clk_sel_i) || !$stable(brr_i)));

endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_framer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              os_tick_i,
    input  logic              sync_mode_i,
    input  logic              two_stop_i,
    input  logic              mp_fmt_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_mpb_i,
    output logic              tx_ready_o,
    output logic              tx_o
);

    localparam int OS_W  = $clog2(OS_RATE);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] shreg;
        logic              extra;
        logic              has_extra;
        logic              second_stop;
        logic              sync_l;
        logic [OS_W-1:0]   os_cnt;
        logic [IDX_W-1:0]  bit_idx;
    } tx_state_t;

    tx_state_t q, d;
    logic      bit_end;

    always_comb begin
        d       = q;
        bit_end = os_tick_i && (q.os_cnt == OS_W'(OS_RATE - 1));
        if (q.phase != PH_IDLE && os_tick_i) begin
            d.os_cnt = bit_end ? '0 : q.os_cnt + 1'b1;
        end
        case (q.phase)
            PH_IDLE: begin
                if (tx_valid_i) begin
                    d.shreg       = tx_data_i;
                    d.extra       = mp_fmt_i ? tx_mpb_i
                                             : (par_odd_i ? ~^tx_data_i : ^tx_data_i);
                    d.has_extra   = !sync_mode_i && (mp_fmt_i || par_en_i);
                    d.second_stop = !sync_mode_i && two_stop_i;
                    d.sync_l      = sync_mode_i;
                    d.os_cnt      = '0;
                    d.bit_idx     = '0;
                    d.phase       = sync_mode_i ? PH_DATA : PH_START;
                end
            end
            PH_START: begin
                if (bit_end) d.phase = PH_DATA;
            end
            PH_DATA: begin
                if (bit_end) begin
                    d.shreg = q.shreg >> 1;
                    if (q.bit_idx == IDX_W'(DATA_W - 1)) begin
                        if (q.sync_l)         d.phase = PH_IDLE;
                        else if (q.has_extra) d.phase = PH_EXTRA;
                        else                  d.phase = PH_STOP;
                    end else begin
                        d.bit_idx = q.bit_idx + 1'b1;
                    end
                end
            end
            PH_EXTRA: begin
                if (bit_end) d.phase = PH_STOP;
            end
            PH_STOP: begin
                if (bit_end) begin
                    if (q.second_stop) d.second_stop = 1'b0;
                    else               d.phase       = PH_IDLE;
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{phase: PH_IDLE, default: '0};
        else         q <= d;
    end

    always_comb begin
        case (q.phase)
            PH_START: tx_o = 1'b0;
            PH_DATA:  tx_o = q.shreg[0];
            PH_EXTRA: tx_o = q.extra;
            default:  tx_o = 1'b1;
        endcase
    end

    assign tx_ready_o = (q.phase == PH_IDLE);

    // R2: an accepted byte makes the transmitter busy on the next cycle
    assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

    // R3: an asynchronous frame always ends on a high stop bit
    assert_ends_on_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tx_ready_o) |-> ($past(tx_o) || $past(q.sync_l)));

endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_framer_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              os_tick_i,
    input  logic              sync_mode_i,
    input  logic              mp_fmt_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              rx_i,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_mpb_o,
    output logic              rx_frame_err_o,
    output logic              rx_parity_err_o
);

    localparam int OS_W  = $clog2(OS_RATE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int HALF  = OS_RATE / 2;

    typedef struct packed {
        logic              meta;
        logic              line;
        logic              prev;
        phase_e            phase;
        logic [OS_W-1:0]   os_cnt;
        logic [IDX_W-1:0]  bit_idx;
        logic [DATA_W-1:0] shreg;
        logic              extra;
        logic              valid;
        logic [DATA_W-1:0] data_out;
        logic              mpb_out;
        logic              ferr;
        logic              perr;
    } rx_state_t;

    rx_state_t q, d;
    logic      has_extra;
    logic      exp_par;
    logic      sample_now;

    always_comb begin
        d          = q;
        d.meta     = rx_i;
        d.line     = q.meta;
        d.valid    = 1'b0;
        has_extra  = mp_fmt_i || par_en_i;
        exp_par    = par_odd_i ? ~^q.shreg : ^q.shreg;
        sample_now = os_tick_i && (q.os_cnt == OS_W'(OS_RATE - 1));
        if (sync_mode_i) begin
            d.phase = PH_IDLE;
            d.prev  = 1'b1;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    if (os_tick_i) begin
                        d.prev = q.line;
                        if (q.prev && !q.line) begin
                            d.phase  = PH_START;
                            d.os_cnt = '0;
                        end
                    end
                end
                PH_START: begin
                    if (os_tick_i) begin
                        if (q.os_cnt == OS_W'(HALF - 1)) begin
                            d.os_cnt  = '0;
                            d.bit_idx = '0;
                            if (!q.line) begin
                                d.phase = PH_DATA;
                            end else begin
                                d.phase = PH_IDLE;
                                d.prev  = 1'b1;
                            end
                        end else begin
                            d.os_cnt = q.os_cnt + 1'b1;
                        end
                    end
                end
                PH_DATA, PH_EXTRA, PH_STOP: begin
                    if (os_tick_i) d.os_cnt = q.os_cnt + 1'b1;
                    if (sample_now) begin
                        d.os_cnt = '0;
                        if (q.phase == PH_DATA) begin
                            d.shreg = {q.line, q.shreg[DATA_W-1:1]};
                            if (q.bit_idx == IDX_W'(DATA_W - 1)) begin
                                d.phase = has_extra ? PH_EXTRA : PH_STOP;
                            end else begin
                                d.bit_idx = q.bit_idx + 1'b1;
                            end
                        end else if (q.phase == PH_EXTRA) begin
                            d.extra = q.line;
                            d.phase = PH_STOP;
                        end else begin
                            d.valid    = 1'b1;
                            d.data_out = q.shreg;
                            d.ferr     = !q.line;
                            d.mpb_out  = mp_fmt_i && q.extra;
                            d.perr     = par_en_i && !mp_fmt_i && (q.extra != exp_par);
                            d.phase    = PH_IDLE;
                            d.prev     = q.line;
                        end
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{meta: 1'b1, line: 1'b1, prev: 1'b1, phase: PH_IDLE, default: '0};
        else         q <= d;
    end

    assign rx_valid_o      = q.valid;
    assign rx_data_o       = q.data_out;
    assign rx_mpb_o        = q.mpb_out;
    assign rx_frame_err_o  = q.ferr;
    assign rx_parity_err_o = q.perr;

    // R10: one pulse per character
    assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o);

    // R8: receiver stays silent in synchronous mode
    assert_sync_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_mode_i |=> !rx_valid_o);

    // R5: multiprocessor format never reports a parity error
    assert_mp_no_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_o && rx_parity_err_o) |-> !$past(mp_fmt_i));

endmodule

// File: rtl/ser_framer.sv
module ser_framer
    import ser_framer_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mode_wr_i,
    input  logic [6:0] mode_i,
    input  logic [7:0] brr_i,
    input  logic       tx_valid_i,
    input  logic [7:0] tx_data_i,
    input  logic       tx_mpb_i,
    output logic       tx_ready_o,
    output logic       tx_o,
    input  logic       rx_i,
    output logic       rx_valid_o,
    output logic [7:0] rx_data_o,
    output logic       rx_mpb_o,
    output logic       rx_frame_err_o,
    output logic       rx_parity_err_o
);

    localparam int DATA_W  = 8;
    localparam int OS_RATE = 16;
    localparam int BRR_W   = 8;

    mode_t mode_q, mode_d;
    logic  os_tick;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr_i) mode_d = mode_t'(mode_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mode_q <= '0;
        else         mode_q <= mode_d;
    end

    ser_rate_gen #(.BRR_W(BRR_W), .PRE_W(6)) rate_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clk_sel_i (mode_q.clk_sel),
        .brr_i     (brr_i),
        .os_tick_o (os_tick)
    );

    ser_tx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) tx_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .os_tick_i   (os_tick),
        .sync_mode_i (mode_q.sync_mode),
        .two_stop_i  (mode_q.two_stop),
        .mp_fmt_i    (mode_q.mp_fmt),
        .par_en_i    (mode_q.par_en),
        .par_odd_i   (mode_q.par_odd),
        .tx_valid_i  (tx_valid_i),
        .tx_data_i   (tx_data_i),
        .tx_mpb_i    (tx_mpb_i),
        .tx_ready_o  (tx_ready_o),
        .tx_o        (tx_o)
    );

    ser_rx #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) rx_u (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .os_tick_i       (os_tick),
        .sync_mode_i     (mode_q.sync_mode),
        .mp_fmt_i        (mode_q.mp_fmt),
        .par_en_i        (mode_q.par_en),
        .par_odd_i       (mode_q.par_odd),
        .rx_i            (rx_i),
        .rx_valid_o      (rx_valid_o),
        .rx_data_o       (rx_data_o),
        .rx_mpb_o        (rx_mpb_o),
        .rx_frame_err_o  (rx_frame_err_o),
        .rx_parity_err_o (rx_parity_err_o)
    );

endmodule

// File: tb/ser_framer_tb_top.sv
module ser_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_wr;
    logic [6:0] mode_v;
    logic [7:0] brr;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_mpb;
    logic       tx_ready, tx_line;
    logic       lb, bb_line;
    logic       rx_line;
    logic       rx_valid, rx_mpb, rx_ferr, rx_perr;
    logic [7:0] rx_data;

    always #5 clk = ~clk;

    assign rx_line = lb ? tx_line : bb_line;

    ser_framer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_i(mode_v), .brr_i(brr),
        .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_mpb_i(tx_mpb),
        .tx_ready_o(tx_ready), .tx_o(tx_line), .rx_i(rx_line),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_mpb_o(rx_mpb),
        .rx_frame_err_o(rx_ferr), .rx_parity_err_o(rx_perr)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_rx = 0;
    logic [10:0] exp_q[$];
    logic [10:0] mon_e;
    logic        prev_valid = 1'b0;
    bit m_sync = 0, m_two = 0, m_mp = 0, m_pe = 0, m_po = 0;
    int m_per = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard side
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            n_rx++;
            chk(!prev_valid, "R10 valid pulse width", 1, 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected character", int'(rx_data), -1);
            end else begin
                mon_e = exp_q.pop_front();
                chk(rx_data == mon_e[7:0], "R2 received byte", int'(rx_data), int'(mon_e[7:0]));
                chk(rx_mpb == mon_e[8], "R5 received mp flag", int'(rx_mpb), int'(mon_e[8]));
                chk(rx_ferr == mon_e[9], "R6 framing flag", int'(rx_ferr), int'(mon_e[9]));
                chk(rx_perr == mon_e[10], "R4 parity flag", int'(rx_perr), int'(mon_e[10]));
            end
        end
        prev_valid = rx_valid;
    end

    task automatic set_mode(input bit sy, input bit two, input bit mp, input bit pe,
                            input bit po, input logic [1:0] cks, input logic [7:0] b);
        @(negedge clk);
        mode_v  = {cks, po, pe, mp, two, sy};
        brr     = b;
        mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
        m_sync = sy; m_two = two; m_mp = mp; m_pe = pe; m_po = po;
        m_per  = (1 << (2 * int'(cks))) * (int'(b) + 1);
    endtask

    // Driver: sends a byte, checks line bits and busy length, pushes expectation
    task automatic tx_frame(input logic [7:0] dat, input logic mpb, output int busy);
        logic bits[16];
        int   n;
        int   cnt;
        int   exp;
        string tag;
        n = 0;
        if (!m_sync) begin bits[n] = 1'b0; n++; end
        for (int i = 0; i < 8; i++) begin bits[n] = dat[i]; n++; end
        if (!m_sync) begin
            if (m_mp)      begin bits[n] = mpb; n++; end
            else if (m_pe) begin bits[n] = m_po ? ~^dat : ^dat; n++; end
            bits[n] = 1'b1; n++;
            if (m_two) begin bits[n] = 1'b1; n++; end
        end
        while (!tx_ready) @(negedge clk);
        tx_data  = dat;
        tx_mpb   = mpb;
        tx_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        if (!m_sync) exp_q.push_back({1'b0, 1'b0, (m_mp ? mpb : 1'b0), dat});
        cnt = 0;
        while (!tx_ready && cnt < 150000) begin
            if (m_per == 1 && cnt % 16 == 8 && cnt / 16 < n)
                chk(tx_line == bits[cnt/16],
                    $sformatf("%s line bit %0d", m_sync ? "R8" : "R2", cnt / 16),
                    int'(tx_line), int'(bits[cnt/16]));
            cnt++;
            @(negedge clk);
        end
        exp = 16 * n * m_per;
        if (m_sync)         tag = "R8 sync frame length";
        else if (m_per > 1) tag = "R7 bit period";
        else                tag = "R3 frame length";
        chk(cnt >= exp - m_per && cnt <= exp + m_per, tag, cnt, exp);
        busy = cnt;
        repeat (40) @(negedge clk);
    endtask

    task automatic bb_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            bb_line = v[i];
            repeat (16) @(negedge clk);
        end
        bb_line = 1'b1;
    endtask

    initial begin
        int busy;
        int n0;
        rst_n = 1'b0; mode_wr = 1'b0; mode_v = '0; brr = '0;
        tx_valid = 1'b0; tx_data = '0; tx_mpb = 1'b0; lb = 1'b1; bb_line = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_line == 1'b1, "R1 idle line after reset", int'(tx_line), 1);
        chk(tx_ready == 1'b1, "R1 ready after reset", int'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R1 no rx valid in reset", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset mode: one stop bit, no extra bit, prescale 1, brr 0
        tx_frame(8'hA5, 1'b0, busy);
        chk(busy == 160, "R1 reset mode frame of 10 bits", busy, 160);
        tx_frame(8'h00, 1'b0, busy);

        // Two stop bits
        set_mode(0, 1, 0, 0, 0, 2'b00, 8'd0);
        tx_frame(8'h3C, 1'b0, busy);

        // Parity even and odd
        set_mode(0, 0, 0, 1, 0, 2'b00, 8'd0);
        tx_frame(8'h07, 1'b0, busy);
        set_mode(0, 0, 0, 1, 1, 2'b00, 8'd0);
        tx_frame(8'h07, 1'b0, busy);
        tx_frame(8'hFF, 1'b0, busy);

        // Multiprocessor format overrides parity
        set_mode(0, 1, 1, 1, 0, 2'b00, 8'd0);
        tx_frame(8'h81, 1'b1, busy);
        chk(busy == 192, "R5 mp frame of 12 bits", busy, 192);
        tx_frame(8'h81, 1'b0, busy);

        // Hand-built frames on the receive line
        lb = 1'b0;
        set_mode(0, 0, 0, 1, 0, 2'b00, 8'd0);
        exp_q.push_back({1'b1, 1'b0, 1'b0, 8'h0F});         // R4 wrong parity
        bb_bits({22'd0, 1'b1, 1'b1, 8'h0F, 1'b0}, 11);
        repeat (32) @(negedge clk);
        exp_q.push_back({1'b0, 1'b1, 1'b0, 8'h12});         // R6 low stop
        bb_bits({22'd0, 1'b0, 1'b0, 8'h12, 1'b0}, 11);
        repeat (48) @(negedge clk);

        // R6: low second-stop slot starts the next character
        set_mode(0, 1, 1, 0, 0, 2'b00, 8'd0);
        exp_q.push_back({1'b0, 1'b0, 1'b1, 8'h55});
        exp_q.push_back({1'b0, 1'b0, 1'b0, 8'hAA});
        bb_bits({9'd0, 2'b11, 1'b0, 8'hAA, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0}, 23);
        repeat (48) @(negedge clk);

        // R9: short low glitch is rejected
        n0 = n_rx;
        bb_line = 1'b0;
        repeat (4) @(negedge clk);
        bb_line = 1'b1;
        repeat (64) @(negedge clk);
        chk(n_rx == n0, "R9 glitch ignored", n_rx - n0, 0);
        lb = 1'b1;

        // R7: clock select and reload
        set_mode(0, 0, 0, 0, 0, 2'b01, 8'd1);
        tx_frame(8'h5A, 1'b0, busy);
        set_mode(0, 0, 0, 0, 0, 2'b10, 8'd2);
        tx_frame(8'hC9, 1'b0, busy);
        set_mode(0, 0, 0, 0, 0, 2'b11, 8'd0);
        tx_frame(8'h1E, 1'b0, busy);

        // R8: synchronous mode ignores framing options, receiver silent
        set_mode(1, 1, 1, 1, 1, 2'b00, 8'd0);
        n0 = n_rx;
        tx_frame(8'hC3, 1'b1, busy);
        repeat (100) @(negedge clk);
        chk(n_rx == n0, "R8 receiver silent", n_rx - n0, 0);

        set_mode(0, 0, 0, 0, 0, 2'b00, 8'd0);
        repeat (100) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all characters received", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule